// File: doc/BRIEF.md
# MDIO Management Master with Register Port

This block is a management-interface master for Ethernet PHYs. It produces the management clock (MDC) from the host clock through a programmable divider. It shifts out Clause 22 frames on the management data line, and for read frames it turns the line around and samples the PHY's reply. The data line is presented as three plain signals (output value, output enable, input value), so a pad cell or the surrounding chip builds the tri-state buffer.

Host software drives the block through a single-cycle register port with four word registers:
- a configuration word that holds the clock divisor and an enable flag;
- a control word that holds the PHY address, the register address, the direction, a start flag and a ready flag;
- a word that stages outgoing write data;
- a word that returns the 16-bit value read from the PHY.

Software sets the divisor so that MDC stays at or below 2.5 MHz, waits for ready, then starts one frame at a time.

Top module: `mdio_host`

## Requirements
- R1: MDC stays low for divisor+1 host cycles and then high for divisor+1 host cycles, so its period is 2·(1+divisor) host cycles. The divisor is captured when a frame starts.
- R2: The configuration word is at address 0. The divisor sits in bits [DIV_W-1:0] and the enable flag in bit 31. Both read back as written. With DIV_W=8, divisors up to 255 are accepted, which keeps MDC at or below 2.5 MHz for host clocks up to 1.28 GHz.
- R3: While enable is 0, MDC stays low. Clearing enable during a frame ends the frame at once: MDC goes low, the data line is released, and no further MDC edges occur.
- R4: The control word is at address 1, with these fields:
  - bit 0: start, which always reads 0;
  - bit 1: ready, read-only;
  - bit 2: direction, 1 for read and 0 for write;
  - bits [12:8]: PHY address;
  - bits [20:16]: register address.
- R5: Ready reads 1 exactly when enable is 1 and no frame is in progress. It reads 0 out of reset, and it reads 0 from the cycle after a start is accepted until the frame ends.
- R6: A write frame sends 64 bits, most significant bit first, sampled at MDC rising edges, in this order:
  - 32 ones;
  - start pattern 01;
  - opcode 01;
  - 5-bit PHY address;
  - 5-bit register address;
  - turnaround 10;
  - the low 16 bits of the write-data word at address 2.
- R7: A read frame sends 32 ones, then 01, then opcode 10, then the two addresses. From bit 46 onward (turnaround and data) the data line is released. The master samples its input on each MDC rising edge. When the frame ends, the last 16 sampled bits appear in bits [15:0] of the read-data word at address 3, and bits [31:16] of that word read 0.
- R8: A write to the control word while ready is 0 is ignored. This covers writes while disabled and writes while busy. No frame starts, and the stored address and direction fields keep their values.
- R9: Outside a frame, MDC is low and the data-line output enable is 0. During a write frame the output enable is 1 at every MDC rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe, one cycle per write |
| regAddr | input | 2 | Word address: 0 configuration, 1 control, 2 write data, 3 read data |
| regWrData | input | 32 | Register write value |
| regRdData | output | 32 | Combinational read value of the addressed word |
| mdioIn | input | 1 | Sampled value of the management data line |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Value driven onto the management data line |
| mdioOe | output | 1 | Drive enable for the management data line |

## Verification
The bench builds the block with the default 8-bit divisor field. It programs divisors of 0, 1, 3 and 49, which cover the fastest MDC the block can make, short odd and even half-periods, and the 2.5 MHz setting for a 250 MHz host clock. The small divisors keep full 64-bit frames short, so the bench can run write frames, read frames, an attempted start while a frame is in flight, and an abort by clearing enable within one run. A PHY model answers read frames on MDC falling edges and records every bit at the rising edges, so the bench can compare frame contents, release points and periods against values it computes itself.

// File: rtl/mdio_host_pkg.sv
package mdio_host_pkg;
  localparam int PRE_BITS    = 32;
  localparam int FRAME_BITS  = PRE_BITS + 32;
  localparam int RELEASE_IDX = PRE_BITS + 14;
  localparam int FLD_W       = 5;
  localparam int DATA_W      = 16;

  localparam logic [1:0] ADDR_CFG  = 2'd0;
  localparam logic [1:0] ADDR_CTL  = 2'd1;
  localparam logic [1:0] ADDR_WDAT = 2'd2;
  localparam logic [1:0] ADDR_RDAT = 2'd3;

  localparam int GO_BIT    = 0;
  localparam int READY_BIT = 1;
  localparam int READ_BIT  = 2;
  localparam int PHY_LSB   = 8;
  localparam int REG_LSB   = 16;
  localparam int EN_BIT    = 31;

  typedef struct packed {
    logic load;
    logic advance;
    logic sample;
    logic finish;
    logic abort;
  } mdioStb_t;
endpackage

// File: rtl/mdio_host_ctrl.sv
module mdio_host_ctrl
  import mdio_host_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgEnable,
  input  logic [DIV_W-1:0] cfgDiv,
  input  logic             startReq,
  output logic             mdc,
  output logic             busy,
  output logic             ready,
  output mdioStb_t         stb
);
  localparam int BIT_W = $clog2(FRAME_BITS);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_BITS - 1);

  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divLat;
  logic [BIT_W-1:0] bitCnt;
  logic             halfDone;

  assign ready    = cfgEnable && !busy;
  assign halfDone = busy && (divCnt == divLat);

  always_comb begin
    stb      = '0;
    stb.load = startReq;
    if (busy && !cfgEnable) begin
      stb.abort = 1'b1;
    end else if (halfDone) begin
      if (!mdc)                   stb.sample  = 1'b1;
      else if (bitCnt == LAST_BIT) stb.finish  = 1'b1;
      else                        stb.advance = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      mdc    <= 1'b0;
      divCnt <= '0;
      divLat <= '0;
      bitCnt <= '0;
    end else if (stb.abort) begin
      busy   <= 1'b0;
      mdc    <= 1'b0;
      divCnt <= '0;
    end else if (stb.load) begin
      busy   <= 1'b1;
      mdc    <= 1'b0;
      divCnt <= '0;
      bitCnt <= '0;
      divLat <= cfgDiv;
    end else if (busy) begin
      if (halfDone) begin
        divCnt <= '0;
        mdc    <= !mdc;
        if (stb.finish)  busy   <= 1'b0;
        if (stb.advance) bitCnt <= bitCnt + 1'b1;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  // R3: a cleared enable leaves MDC low on the next cycle
  p_no_mdc_when_off_r3: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEnable |=> !mdc);

  // R1: every MDC rise closes a low phase of divisor+1 cycles
  p_rise_after_half_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mdc) |-> ($past(divCnt) == $past(divLat)));

  // R1: every regular MDC fall closes a high phase of divisor+1 cycles
  p_fall_after_half_r1: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(mdc) && $past(cfgEnable)) |-> ($past(divCnt) == $past(divLat)));

  // R8: a frame only starts from the ready state
  p_start_from_ready_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(ready));
endmodule

// File: rtl/mdio_host_dp.sv
module mdio_host_dp
  import mdio_host_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [1:0]       regAddr,
  input  logic [31:0]      regWrData,
  output logic [31:0]      regRdData,
  input  logic             ready,
  input  logic             busy,
  input  mdioStb_t         stb,
  input  logic             mdioIn,
  output logic             mdioOut,
  output logic             mdioOe,
  output logic             startReq,
  output logic             cfgEnable,
  output logic [DIV_W-1:0] cfgDiv
);
  logic [FLD_W-1:0]      ctlPhy, ctlReg, newPhy, newReg;
  logic                  ctlRead, newRead, frameRead, ctlWrOk;
  logic [DATA_W-1:0]     wrData, rdData, rdShift;
  logic [FRAME_BITS-1:0] outShift, oeShift, newFrame, newMask;
  logic                  unusedWr;

  assign unusedWr = ^regWrData;
  assign ctlWrOk  = regWrEn && (regAddr == ADDR_CTL) && ready;
  assign startReq = ctlWrOk && regWrData[GO_BIT];
  assign newRead  = regWrData[READ_BIT];
  assign newPhy   = regWrData[PHY_LSB +: FLD_W];
  assign newReg   = regWrData[REG_LSB +: FLD_W];

  assign newFrame = {{PRE_BITS{1'b1}}, 2'b01, (newRead ? 2'b10 : 2'b01),
                     newPhy, newReg, (newRead ? 2'b11 : 2'b10),
                     (newRead ? {DATA_W{1'b1}} : wrData)};
  assign newMask  = newRead ? {{RELEASE_IDX{1'b1}}, {(FRAME_BITS-RELEASE_IDX){1'b0}}}
                            : {FRAME_BITS{1'b1}};

  assign mdioOut = outShift[FRAME_BITS-1];
  assign mdioOe  = oeShift[FRAME_BITS-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgEnable <= 1'b0;
      cfgDiv    <= '0;
      ctlPhy    <= '0;
      ctlReg    <= '0;
      ctlRead   <= 1'b0;
      wrData    <= '0;
      rdData    <= '0;
      rdShift   <= '0;
      outShift  <= '0;
      oeShift   <= '0;
      frameRead <= 1'b0;
    end else begin
      if (regWrEn && regAddr == ADDR_CFG) begin
        cfgEnable <= regWrData[EN_BIT];
        cfgDiv    <= regWrData[DIV_W-1:0];
      end
      if (regWrEn && regAddr == ADDR_WDAT) wrData <= regWrData[DATA_W-1:0];
      if (ctlWrOk) begin
        ctlPhy  <= newPhy;
        ctlReg  <= newReg;
        ctlRead <= newRead;
      end
      if (stb.load) begin
        outShift  <= newFrame;
        oeShift   <= newMask;
        frameRead <= newRead;
      end else if (stb.advance) begin
        outShift <= {outShift[FRAME_BITS-2:0], 1'b1};
        oeShift  <= {oeShift[FRAME_BITS-2:0], 1'b0};
      end else if (stb.finish || stb.abort) begin
        oeShift <= '0;
      end
      if (stb.sample && frameRead && !oeShift[FRAME_BITS-1])
        rdShift <= {rdShift[DATA_W-2:0], mdioIn};
      if (stb.finish && frameRead) rdData <= rdShift;
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_CFG: begin
        regRdData[EN_BIT]      = cfgEnable;
        regRdData[DIV_W-1:0]   = cfgDiv;
      end
      ADDR_CTL: begin
        regRdData[READY_BIT]         = ready;
        regRdData[READ_BIT]          = ctlRead;
        regRdData[PHY_LSB +: FLD_W]  = ctlPhy;
        regRdData[REG_LSB +: FLD_W]  = ctlReg;
      end
      ADDR_WDAT: regRdData[DATA_W-1:0] = wrData;
      default:   regRdData[DATA_W-1:0] = rdData;
    endcase
  end

  // R9: the data line is only driven inside a frame
  p_oe_only_in_frame_r9: assert property (@(posedge clk) disable iff (!rstN)
    mdioOe |-> busy);

  // R7: read data changes only when a frame completes
  p_rddata_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !stb.finish |=> $stable(rdData));
endmodule

// File: rtl/mdio_host.sv
module mdio_host
  import mdio_host_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [1:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic        mdioIn,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe
);
  mdioStb_t         stb;
  logic             ready, busy, startReq, cfgEnable;
  logic [DIV_W-1:0] cfgDiv;

  mdio_host_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgDiv(cfgDiv),
    .startReq(startReq), .mdc(mdc), .busy(busy), .ready(ready), .stb(stb)
  );

  mdio_host_dp #(.DIV_W(DIV_W)) u_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .ready(ready), .busy(busy),
    .stb(stb), .mdioIn(mdioIn), .mdioOut(mdioOut), .mdioOe(mdioOe),
    .startReq(startReq), .cfgEnable(cfgEnable), .cfgDiv(cfgDiv)
  );
endmodule

// File: tb/mdio_host_tb.sv
module mdio_host_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        mdioIn = 1'b1;
  logic        mdc, mdioOut, mdioOe;

  int          total = 0;
  int          failed = 0;
  bit          doneFlag = 0;
  int          cycCnt = 0;
  int          lastRise = 0;
  int          period = 0;
  int          riseCnt = 0;
  logic [63:0] capBits = '0;
  logic [63:0] capOe = '0;
  logic [15:0] phyData = '0;
  bit          phyActive = 0;

  always #2 clk = ~clk;

  mdio_host u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .mdioIn(mdioIn),
    .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe)
  );

  always @(negedge clk) cycCnt = cycCnt + 1;

  always @(posedge mdc) begin
    if (riseCnt < 64) begin
      capBits[63-riseCnt] = mdioOut;
      capOe[63-riseCnt]   = mdioOe;
    end
    period   = cycCnt - lastRise;
    lastRise = cycCnt;
    riseCnt  = riseCnt + 1;
  end

  // PHY model: changes its reply on MDC falling edges
  always @(negedge mdc) begin
    if (phyActive && riseCnt == 47) mdioIn = 1'b0;
    else if (phyActive && riseCnt >= 48 && riseCnt < 64) mdioIn = phyData[63-riseCnt];
    else mdioIn = 1'b1;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRd(input logic [1:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  function automatic logic [31:0] ctlWord(input logic [4:0] phy, input logic [4:0] rg,
                                          input logic rd, input logic go);
    return {11'd0, rg, 3'd0, phy, 5'd0, rd, 1'b0, go};
  endfunction

  task automatic waitIdle();
    logic [31:0] v;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      regRd(2'd1, v);
      if (v[1]) break;
    end
  endtask

  task automatic testReset();
    logic [31:0] v;
    regRd(2'd1, v); chk("R5 ready low after reset", v, 32'h0);
    regRd(2'd0, v); chk("R2 config reset value", v, 32'h0);
    chk("R9 mdc idle low", mdc, 0);
    chk("R9 oe idle low", mdioOe, 0);
  endtask

  task automatic testDisabledStart();
    logic [31:0] v;
    riseCnt = 0;
    regWr(2'd1, ctlWord(5'h11, 5'h05, 1'b0, 1'b1));
    repeat (20) @(negedge clk);
    chk("R8 R3 no MDC while disabled", riseCnt, 0);
    regRd(2'd1, v); chk("R8 fields kept while disabled", v, 32'h0);
  endtask

  task automatic testEnable();
    logic [31:0] v;
    regWr(2'd0, 32'h8000_0001);
    regRd(2'd0, v); chk("R2 config readback", v, 32'h8000_0001);
    regRd(2'd1, v); chk("R5 ready after enable", v[1], 1);
  endtask

  task automatic testWrite();
    logic [31:0] v;
    regWr(2'd2, 32'h0000_A5C3);
    riseCnt = 0; phyActive = 0;
    regWr(2'd1, ctlWord(5'h13, 5'h0A, 1'b0, 1'b1));
    regRd(2'd1, v);
    chk("R5 ready low while busy", v[1], 0);
    chk("R4 start bit reads zero", v[0], 0);
    waitIdle();
    chk("R6 rising edge count", riseCnt, 64);
    chk("R6 write frame bits", capBits,
        {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h13, 5'h0A, 2'b10, 16'hA5C3});
    chk("R9 oe held during write", capOe, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R1 period div=1", period, 4);
    chk("R9 mdc low after frame", mdc, 0);
    chk("R9 oe low after frame", mdioOe, 0);
    regRd(2'd1, v); chk("R4 control readback", v, 32'h000A_1302);
  endtask

  task automatic testRead(input logic [7:0] dv, input logic [4:0] phy,
                          input logic [4:0] rg, input logic [15:0] val);
    logic [31:0] v;
    regWr(2'd0, {24'h800000, dv});
    phyData = val; phyActive = 1; riseCnt = 0;
    regWr(2'd1, ctlWord(phy, rg, 1'b1, 1'b1));
    waitIdle();
    phyActive = 0;
    chk("R7 read header bits", capBits[63:18], {32'hFFFF_FFFF, 2'b01, 2'b10, phy, rg});
    chk("R7 release from turnaround", capOe, {{46{1'b1}}, 18'd0});
    regRd(2'd3, v); chk("R7 read data with zero upper half", v, {16'h0, val});
    chk("R1 read period", period, 2 * (dv + 1));
    regRd(2'd1, v); chk("R4 read direction kept", v[2], 1);
  endtask

  task automatic testBusyIgnore();
    logic [31:0] v;
    regWr(2'd0, 32'h8000_0003);
    regWr(2'd2, 32'h0000_1234);
    riseCnt = 0;
    regWr(2'd1, ctlWord(5'h07, 5'h03, 1'b0, 1'b1));
    repeat (30) @(negedge clk);
    regWr(2'd1, ctlWord(5'h1E, 5'h1C, 1'b1, 1'b1));
    waitIdle();
    chk("R8 frame unchanged by busy start", capBits,
        {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h07, 5'h03, 2'b10, 16'h1234});
    chk("R1 period div=3", period, 8);
    repeat (40) @(negedge clk);
    chk("R8 no second frame", riseCnt, 64);
    regRd(2'd1, v); chk("R8 fields kept while busy", v, 32'h0003_0702);
  endtask

  task automatic testAbort();
    logic [31:0] v;
    int seen;
    riseCnt = 0;
    regWr(2'd1, ctlWord(5'h02, 5'h04, 1'b0, 1'b1));
    repeat (50) @(negedge clk);
    regWr(2'd0, 32'h0000_0003);
    @(negedge clk);
    chk("R3 mdc low after disable", mdc, 0);
    chk("R3 oe released after disable", mdioOe, 0);
    seen = riseCnt;
    repeat (50) @(negedge clk);
    chk("R3 no MDC edges after disable", riseCnt, seen);
    regRd(2'd1, v); chk("R5 ready low when disabled", v[1], 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDisabledStart();
    testEnable();
    testWrite();
    testRead(8'd0, 5'h01, 5'h1F, 16'h6E29);
    testBusyIgnore();
    testRead(8'd49, 5'h15, 5'h0C, 16'hBEEF);
    testAbort();
    if (!doneFlag) begin
      doneFlag = 1;
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!doneFlag) begin
      doneFlag = 1;
      total++; failed++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end
endmodule